// File: doc/BRIEF.md
# Battery-Backed SRAM Power Supervisor

This controller sits between a host processor and a static RAM that is kept alive by a rechargeable cell. Analog comparators outside the block report four supply conditions as level flags. Two flags mark the supply below each of the two write-protect trip points, one at 5 percent and one at 10 percent under nominal. A third flag marks the supply below the cell voltage, and a fourth marks it below the lower power-switchover level. A static select input picks which trip point applies.

From these flags the block does five things. It gates the host's chip-enable and write-enable before they reach the RAM, so a sagging supply cannot corrupt data. It chooses whether the RAM runs from the external rail or from the cell. It enables the charger. It keeps a one-time latch that connects the cell for the first time. It drives an open-drain, active-low reset for the host.

Write protection and the host reset are released only after the supply has stayed above the trip point for a run of clock cycles. Each run length is set by its own parameter. The reset run is the longer of the two, so the RAM is already usable when the host leaves reset.

Top module: `nvsram_supervisor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the outputs are: `wp_active`=1, `ram_ce_n`=1, `ram_we_n`=1, `chg_en`=0, `batt_link`=0, `batt_sel`=0, `host_rst_pull`=0. This holds while all four flags read 1 (no supply).
- R2: With `tol_sel`=0 the effective trip flag is `cmp_trip5`. With `tol_sel`=1 it is `cmp_trip10`. The flag that is not selected has no effect on any output.
- R3: Three clock edges after the effective trip flag rises, `wp_active`=1 and `ram_ce_n`=`ram_we_n`=1, whatever the host drives.
- R4: While `wp_active`=0, `ram_ce_n` and `ram_we_n` equal `host_ce_n` and `host_we_n` as they were one clock edge earlier.
- R5: After the effective trip flag falls and stays low, `wp_active` falls on exactly the (REC_CYC+3)th clock edge.
- R6: `host_rst_pull`=1 (reset driven low) while `cmp_below_batt`=0 and either the trip flag is high or the timeout is pending. It releases on the (RST_CYC+3)th edge after the trip flag falls. RST_CYC is larger than REC_CYC.
- R7: Three edges after `cmp_below_batt` rises, `host_rst_pull`=0.
- R8: If the trip flag rises during either count, both counts restart from zero when it falls again.
- R9: `batt_sel`=1 (RAM runs from the cell) three edges after `cmp_below_sw` rises, but only if `batt_link`=1. It returns to 0 three edges after `cmp_below_sw` falls.
- R10: `chg_en` is 1 exactly while the effective trip flag, as seen three edges earlier, is low.
- R11: `batt_link` sets three edges after the trip flag is first seen low and then stays set until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tol_sel | input | 1 | Trip select: 0 = 5 percent, 1 = 10 percent |
| cmp_trip5 | input | 1 | Supply below 5 percent trip point |
| cmp_trip10 | input | 1 | Supply below 10 percent trip point |
| cmp_below_batt | input | 1 | Supply below cell voltage |
| cmp_below_sw | input | 1 | Supply below switchover level |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| ram_ce_n | output | 1 | Gated chip-enable to RAM |
| ram_we_n | output | 1 | Gated write-enable to RAM |
| wp_active | output | 1 | Write protection in force |
| batt_sel | output | 1 | 1 = RAM powered from cell |
| chg_en | output | 1 | Charger enable |
| batt_link | output | 1 | Cell connected for backup |
| host_rst_pull | output | 1 | Open-drain enable: 1 pulls host reset low |

## Verification
A flag change passes two synchronizer flops and one output register. Its effect therefore appears on the third rising edge after the flag is driven. The host strobes pass only the output register and appear one edge later. `tol_sel` is not synchronized, so a select change reaches `chg_en` on the first edge, and a released count ends on edge REC_CYC+1.

The bench drives every input on a falling edge and counts rising edges from that point. Each result is read on the falling edge just after its due edge. Both sides of each boundary are read: REC_CYC+2 and REC_CYC+3 edges for protection, and RST_CYC+2 and RST_CYC+3 edges for reset.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef struct packed {
    logic below_sw;
    logic below_batt;
    logic trip10;
    logic trip5;
  } supply_flags_t;

  localparam int unsigned NUM_FLAGS = $bits(supply_flags_t);

endpackage

// File: rtl/nvs_flag_sync.sv
module nvs_flag_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  // Each flag gets its own shift chain; reset value 1 means "no supply".
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/nvs_hold_timer.sv
module nvs_hold_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);

  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  // Saturating count of consecutive cycles without clr.
  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (cnt != W'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == W'(LIMIT));

endmodule

// File: rtl/nvsram_supervisor.sv
module nvsram_supervisor #(
  parameter int unsigned REC_CYC     = 12_500_000,
  parameter int unsigned RST_CYC     = 35_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tol_sel,
  input  logic cmp_trip5,
  input  logic cmp_trip10,
  input  logic cmp_below_batt,
  input  logic cmp_below_sw,
  input  logic host_ce_n,
  input  logic host_we_n,
  output logic ram_ce_n,
  output logic ram_we_n,
  output logic wp_active,
  output logic batt_sel,
  output logic chg_en,
  output logic batt_link,
  output logic host_rst_pull
);
  import nvs_pkg::*;

  supply_flags_t             raw_f, syn_f;
  logic [NUM_FLAGS-1:0]      syn_vec;
  logic                      trip;
  logic                      rec_done, rst_done, lock;

  assign raw_f = '{below_sw: cmp_below_sw, below_batt: cmp_below_batt,
                   trip10: cmp_trip10, trip5: cmp_trip5};

  nvs_flag_sync #(.N(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din (raw_f), .dout (syn_vec)
  );
  assign syn_f = supply_flags_t'(syn_vec);

  // Tolerance select picks the comparator that defines "out of tolerance".
  assign trip = tol_sel ? syn_f.trip10 : syn_f.trip5;

  nvs_hold_timer #(.LIMIT(REC_CYC)) u_rec_timer (
    .clk (clk), .rst (rst), .clr (trip), .done (rec_done)
  );

  nvs_hold_timer #(.LIMIT(RST_CYC)) u_rst_timer (
    .clk (clk), .rst (rst), .clr (trip), .done (rst_done)
  );

  assign lock = trip | ~rec_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_active     <= 1'b1;
      ram_ce_n      <= 1'b1;
      ram_we_n      <= 1'b1;
      chg_en        <= 1'b0;
      batt_link     <= 1'b0;
      batt_sel      <= 1'b0;
      host_rst_pull <= 1'b0;
    end else begin
      wp_active     <= lock;
      ram_ce_n      <= lock | host_ce_n;
      ram_we_n      <= lock | host_we_n;
      chg_en        <= ~trip;
      batt_link     <= batt_link | ~trip;
      batt_sel      <= syn_f.below_sw & batt_link;
      host_rst_pull <= ~syn_f.below_batt & (trip | ~rst_done);
    end
  end

endmodule

// File: rtl/nvs_supervisor_checker.sv
module nvs_supervisor_checker (
  input logic clk,
  input logic rst,
  input logic host_ce_n,
  input logic host_we_n,
  input logic ram_ce_n,
  input logic ram_we_n,
  input logic wp_active,
  input logic batt_sel,
  input logic chg_en,
  input logic batt_link,
  input logic host_rst_pull
);

  a_r3_gate_closed: assert property (@(posedge clk) disable iff (rst)
    wp_active |-> (ram_ce_n && ram_we_n));

  a_r4_pass_through: assert property (@(posedge clk) disable iff (rst)
    !wp_active |-> (ram_ce_n == $past(host_ce_n) && ram_we_n == $past(host_we_n)));

  a_r5_release_in_tolerance: assert property (@(posedge clk) disable iff (rst)
    $fell(wp_active) |-> chg_en);

  a_r6_reset_outlasts_protect: assert property (@(posedge clk) disable iff (rst)
    (chg_en && !host_rst_pull) |-> !wp_active);

  a_r7_no_pull_on_cell: assert property (@(posedge clk) disable iff (rst)
    batt_sel |-> !host_rst_pull);

  a_r10_charge_needs_link: assert property (@(posedge clk) disable iff (rst)
    chg_en |-> batt_link);

  a_r11_link_sticky: assert property (@(posedge clk) disable iff (rst)
    batt_link |=> batt_link);

endmodule

bind nvsram_supervisor nvs_supervisor_checker u_chk (.*);

// File: tb/nvsram_supervisor_bench.sv
module nvsram_supervisor_bench;

  localparam int REC = 20;
  localparam int RST = 50;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, tol_sel, t5, t10, bbat, bsw, hce, hwe;
  logic ram_ce_n, ram_we_n, wp_active, batt_sel, chg_en, batt_link, host_rst_pull;

  int n_chk = 0;
  int n_err = 0;

  nvsram_supervisor #(.REC_CYC(REC), .RST_CYC(RST)) u_nvsram_supervisor (
    .clk (clk), .rst (rst), .tol_sel (tol_sel),
    .cmp_trip5 (t5), .cmp_trip10 (t10), .cmp_below_batt (bbat), .cmp_below_sw (bsw),
    .host_ce_n (hce), .host_we_n (hwe),
    .ram_ce_n (ram_ce_n), .ram_we_n (ram_we_n), .wp_active (wp_active),
    .batt_sel (batt_sel), .chg_en (chg_en), .batt_link (batt_link),
    .host_rst_pull (host_rst_pull)
  );

  typedef enum {LV_OFF, LV_CELL, LV_MID, LV_BETWEEN, LV_GOOD} lvl_t;

  task automatic check(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_level(lvl_t l);
    case (l)
      LV_OFF:     begin bsw = 1; bbat = 1; t10 = 1; t5 = 1; end
      LV_CELL:    begin bsw = 0; bbat = 1; t10 = 1; t5 = 1; end
      LV_MID:     begin bsw = 0; bbat = 0; t10 = 1; t5 = 1; end
      LV_BETWEEN: begin bsw = 0; bbat = 0; t10 = 0; t5 = 1; end
      default:    begin bsw = 0; bbat = 0; t10 = 0; t5 = 0; end
    endcase
  endtask

  task automatic settle_good();
    set_level(LV_GOOD);
    step(RST + 5);
  endtask

  task automatic t_reset();
    check("R1", "wp_active", wp_active, 1'b1);
    check("R1", "ram_ce_n", ram_ce_n, 1'b1);
    check("R1", "ram_we_n", ram_we_n, 1'b1);
    check("R1", "chg_en", chg_en, 1'b0);
    check("R1", "batt_link", batt_link, 1'b0);
    check("R1", "batt_sel", batt_sel, 1'b0);
    check("R1", "host_rst_pull", host_rst_pull, 1'b0);
  endtask

  task automatic t_powerup();
    set_level(LV_GOOD);
    hce = 0; hwe = 0;
    step(3);
    check("R10", "chg_en on", chg_en, 1'b1);
    check("R11", "link set", batt_link, 1'b1);
    check("R5", "wp during count", wp_active, 1'b1);
    check("R3", "ce blocked", ram_ce_n, 1'b1);
    check("R3", "we blocked", ram_we_n, 1'b1);
    check("R6", "reset held", host_rst_pull, 1'b1);
    step(REC - 1);
    check("R5", "wp at REC+2", wp_active, 1'b1);
    step(1);
    check("R5", "wp at REC+3", wp_active, 1'b0);
    check("R4", "ce follows", ram_ce_n, 1'b0);
    hce = 1; hwe = 0;
    step(1);
    check("R4", "ce follows high", ram_ce_n, 1'b1);
    check("R4", "we follows low", ram_we_n, 1'b0);
    step(RST - REC - 2);
    check("R6", "reset at RST+2", host_rst_pull, 1'b1);
    step(1);
    check("R6", "reset at RST+3", host_rst_pull, 1'b0);
    hwe = 1;
  endtask

  task automatic t_brownout();
    hce = 0;
    step(1);
    check("R4", "ce low before dip", ram_ce_n, 1'b0);
    set_level(LV_BETWEEN);
    step(2);
    check("R3", "wp not yet", wp_active, 1'b0);
    step(1);
    check("R3", "wp on", wp_active, 1'b1);
    check("R3", "ce forced high", ram_ce_n, 1'b1);
    check("R10", "chg off", chg_en, 1'b0);
    check("R6", "reset on dip", host_rst_pull, 1'b1);
    check("R11", "link kept", batt_link, 1'b1);
    hce = 1;
  endtask

  task automatic t_sel();
    tol_sel = 1;
    step(1);
    check("R2", "chg on with 10pct", chg_en, 1'b1);
    step(REC - 1);
    check("R2", "wp before release", wp_active, 1'b1);
    step(1);
    check("R2", "wp released", wp_active, 1'b0);
    t5 = 0;
    step(4);
    check("R2", "t5 low ignored wp", wp_active, 1'b0);
    t5 = 1;
    step(4);
    check("R2", "t5 high ignored wp", wp_active, 1'b0);
    check("R2", "t5 high ignored chg", chg_en, 1'b1);
    set_level(LV_GOOD);
    step(3);
    tol_sel = 0;
    step(RST + 5);
  endtask

  task automatic t_dip();
    set_level(LV_BETWEEN);
    step(3);
    check("R8", "wp on dip", wp_active, 1'b1);
    set_level(LV_GOOD);
    step(REC / 2);
    set_level(LV_BETWEEN);
    step(2);
    set_level(LV_GOOD);
    step(REC + 2);
    check("R8", "wp restart REC+2", wp_active, 1'b1);
    step(1);
    check("R8", "wp restart REC+3", wp_active, 1'b0);
    step(RST - REC - 1);
    check("R8", "reset restart RST+2", host_rst_pull, 1'b1);
    step(1);
    check("R8", "reset restart RST+3", host_rst_pull, 1'b0);
  endtask

  task automatic t_powerdown();
    set_level(LV_MID);
    step(3);
    check("R6", "reset below trip", host_rst_pull, 1'b1);
    check("R9", "still external", batt_sel, 1'b0);
    set_level(LV_CELL);
    step(2);
    check("R7", "reset before cell", host_rst_pull, 1'b1);
    step(1);
    check("R7", "reset released below cell", host_rst_pull, 1'b0);
    set_level(LV_OFF);
    step(2);
    check("R9", "switch not yet", batt_sel, 1'b0);
    step(1);
    check("R9", "on cell", batt_sel, 1'b1);
    set_level(LV_CELL);
    step(3);
    check("R9", "back external", batt_sel, 1'b0);
    set_level(LV_MID);
    step(3);
    check("R6", "reset on rise", host_rst_pull, 1'b1);
    settle_good();
  endtask

  task automatic t_seal();
    set_level(LV_OFF);
    rst = 1;
    step(3);
    rst = 0;
    step(4);
    check("R11", "sealed link", batt_link, 1'b0);
    check("R9", "no cell while sealed", batt_sel, 1'b0);
    set_level(LV_GOOD);
    step(3);
    check("R11", "link on first rise", batt_link, 1'b1);
    set_level(LV_OFF);
    step(3);
    check("R11", "link stays", batt_link, 1'b1);
    check("R9", "cell after link", batt_sel, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1; tol_sel = 0; hce = 1; hwe = 1;
    set_level(LV_OFF);
    step(5);
    rst = 0;
    step(1);
    t_reset();
    t_powerup();
    t_brownout();
    t_sel();
    t_dip();
    t_powerdown();
    t_seal();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule